// File: doc/BRIEF.md
# Chained 32-bit Time Counter

This block is a wide free-running time base made of two equal counter channels. The lower channel advances on a tick taken from a prescaler of the system clock, with the division picked by a tap select input. Its count runs freely through the whole range and wraps. From its own count it builds a square wave that goes high when the count wraps to zero and low at half range. The upper channel does not take a carry. It counts the rising edges of that square wave, after bringing them through a synchronizer into the system clock domain. The upper count therefore holds the number of lower-channel wraps, and `{hi_count, lo_count}` forms the full time value.

Each channel has its own start and stop command. A single sync command clears both counts, the square wave, the prescaler phase and any edge still in the synchronizer, all in the same cycle. After a wrap, the upper count trails the lower count by a few cycles. Software that needs a consistent value reads upper, then lower, then upper again, and repeats until the two upper reads agree.

Top module: `chained_time_counter`

## Requirements
- R1: After reset both counts and `lo_wave` are 0 and both channels are stopped, so both counts stay 0 until a start command.
- R2: `div_sel` value s sets the tick period to d = 2^(2s+1) cycles (2, 8, 32, 128). After a sync the first lower-count step lands d cycles later, and one step follows every d cycles after that.
- R3: The lower count steps by one on each tick and runs through its whole range. It goes from all-ones back to 0 with no reset on compare.
- R4: `lo_wave` is 0 after reset or sync. It rises when the lower count wraps to 0 and falls when the lower count reaches half range (only the top bit set).
- R5: The upper count steps by exactly one for each rising edge of `lo_wave`. The step shows up 3 cycles after the wrap (two synchronizer stages plus the edge register).
- R6: The upper count also runs through its whole range and wraps to 0.
- R7: Bit 0 of `chan_start` / `chan_stop` commands the lower channel and bit 1 commands the upper channel. A start pulse enables the channel and a stop pulse disables it. When both are set in the same cycle, stop wins. A disabled channel holds its count.
- R8: `sync_all` clears both counts, `lo_wave`, the prescaler phase and edges still pending in the synchronizer, and leaves both enables unchanged.
- R9: Rising edges of `lo_wave` that arrive while the upper channel is stopped are lost. They are not counted when the channel is started again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | SEL_W | Prescaler tap select |
| chan_start | input | 2 | Per-channel start pulse (bit 0 lower, bit 1 upper) |
| chan_stop | input | 2 | Per-channel stop pulse, overrides start |
| sync_all | input | 1 | Clear both counts and the prescaler phase together |
| lo_count | output | CNT_W | Lower channel count |
| hi_count | output | CNT_W | Upper channel count (wrap count of the lower channel) |
| lo_wave | output | 1 | Half-duty square wave from the lower channel |

## Verification
A prescaler that has lost its phase, or a wrong tap decode, shows up on `lo_count` at the very first tick after a sync, because the step lands one or more cycles off. A bad compare value or a bad wave register shows on `lo_wave` within one lower-count period. A synchronizer that is too deep, too shallow, or not flushed shows on `hi_count` within three cycles of the first wrap, or of a sync placed right after a wrap. The bench runs over every tap on a narrow counter and predicts all three outputs arithmetically, cycle by cycle, from the number of cycles since the sync.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

  typedef enum int {
    CH_LO = 0,
    CH_HI = 1
  } chan_id_e;

  localparam int NUM_CHAN = 2;

  // Width of the prescaler bit field that must be all ones for a tap to fire.
  function automatic int tap_shift(input int sel, input int base, input int step);
    return base + step * sel;
  endfunction

endpackage

// File: rtl/ctc_prescaler.sv
module ctc_prescaler #(
  parameter int SEL_W    = 2,
  parameter int TAP_BASE = 1,
  parameter int TAP_STEP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NUM_TAPS = 1 << SEL_W;
  localparam int PRE_W    = ctc_pkg::tap_shift(NUM_TAPS - 1, TAP_BASE, TAP_STEP);

  logic [PRE_W-1:0]    pre_cnt;
  logic [NUM_TAPS-1:0] tap_hit;

  always_ff @(posedge clk) begin
    if (rst || clr) pre_cnt <= '0;
    else            pre_cnt <= pre_cnt + PRE_W'(1);
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int SH = ctc_pkg::tap_shift(g, TAP_BASE, TAP_STEP);
    assign tap_hit[g] = &pre_cnt[SH-1:0];
  end

  assign tick = tap_hit[sel];

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R2

  AST_CLR_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    clr |=> !tick); // R8

endmodule

// File: rtl/ctc_edge_sync.sv
module ctc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] stage_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      stage_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      stage_q <= {stage_q[STAGES-2:0], din};
      prev_q  <= stage_q[STAGES-1];
    end
  end

  assign rise = stage_q[STAGES-1] & ~prev_q;

  AST_RISE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R5

endmodule

// File: rtl/ctc_channel.sv
module ctc_channel #(
  parameter int CNT_W    = 16,
  parameter bit HAS_WAVE = 1'b0,
  parameter int CMP_SET  = 0,
  parameter int CMP_CLR  = 1 << (CNT_W - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             start,
  input  logic             stop,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             wave
);
  localparam logic [CNT_W-1:0] SET_V = CNT_W'(CMP_SET);
  localparam logic [CNT_W-1:0] CLR_V = CNT_W'(CMP_CLR);

  logic             en_q;
  logic [CNT_W-1:0] nxt;
  logic             adv;

  assign nxt = count + CNT_W'(1);
  assign adv = en_q & step;

  always_ff @(posedge clk) begin
    if (rst)        en_q <= 1'b0;
    else if (stop)  en_q <= 1'b0;
    else if (start) en_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (adv)   count <= nxt;
  end

  if (HAS_WAVE) begin : g_wave
    logic wave_q;
    always_ff @(posedge clk) begin
      if (rst || clr)  wave_q <= 1'b0;
      else if (adv) begin
        if (nxt == SET_V)      wave_q <= 1'b1;
        else if (nxt == CLR_V) wave_q <= 1'b0;
      end
    end
    assign wave = wave_q;

    AST_WAVE_RISE: assert property (@(posedge clk) disable iff (rst)
      $rose(wave) |-> count == SET_V); // R4

    AST_WAVE_FALL: assert property (@(posedge clk) disable iff (rst)
      ($fell(wave) && !$past(clr)) |-> count == CLR_V); // R4
  end else begin : g_nowave
    assign wave = 1'b0;
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !clr) |=> $stable(count)); // R7

  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0); // R8

endmodule

// File: rtl/chained_time_counter.sv
module chained_time_counter #(
  parameter int CNT_W       = 16,
  parameter int SEL_W       = 2,
  parameter int TAP_BASE    = 1,
  parameter int TAP_STEP    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] div_sel,
  input  logic [1:0]       chan_start,
  input  logic [1:0]       chan_stop,
  input  logic             sync_all,
  output logic [CNT_W-1:0] lo_count,
  output logic [CNT_W-1:0] hi_count,
  output logic             lo_wave
);
  import ctc_pkg::*;

  localparam int HALF = 1 << (CNT_W - 1);

  logic tick;
  logic hi_step;
  logic unused_hi_wave;

  ctc_prescaler #(
    .SEL_W   (SEL_W),
    .TAP_BASE(TAP_BASE),
    .TAP_STEP(TAP_STEP)
  ) u_pre (
    .clk (clk),
    .rst (rst),
    .clr (sync_all),
    .sel (div_sel),
    .tick(tick)
  );

  ctc_channel #(
    .CNT_W   (CNT_W),
    .HAS_WAVE(1'b1),
    .CMP_SET (0),
    .CMP_CLR (HALF)
  ) u_lo (
    .clk  (clk),
    .rst  (rst),
    .clr  (sync_all),
    .start(chan_start[CH_LO]),
    .stop (chan_stop[CH_LO]),
    .step (tick),
    .count(lo_count),
    .wave (lo_wave)
  );

  ctc_edge_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .clr (sync_all),
    .din (lo_wave),
    .rise(hi_step)
  );

  ctc_channel #(
    .CNT_W   (CNT_W),
    .HAS_WAVE(1'b0),
    .CMP_SET (0),
    .CMP_CLR (HALF)
  ) u_hi (
    .clk  (clk),
    .rst  (rst),
    .clr  (sync_all),
    .start(chan_start[CH_HI]),
    .stop (chan_stop[CH_HI]),
    .step (hi_step),
    .count(hi_count),
    .wave (unused_hi_wave)
  );

  AST_HI_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    !sync_all |=> (hi_count == $past(hi_count) ||
                   hi_count == $past(hi_count) + CNT_W'(1))); // R5

  AST_LO_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    !sync_all |=> (lo_count == $past(lo_count) ||
                   lo_count == $past(lo_count) + CNT_W'(1))); // R3

endmodule

// File: tb/chained_time_counter_bench.sv
module chained_time_counter_bench;
  localparam int W    = 6;
  localparam int MOD  = 1 << W;
  localparam int HALF = 1 << (W - 1);
  localparam int LAT  = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   div_sel = 2'd0;
  logic [1:0]   chan_start = 2'b00;
  logic [1:0]   chan_stop = 2'b00;
  logic         sync_all = 1'b0;
  logic [W-1:0] lo_count, hi_count;
  logic         lo_wave;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  chained_time_counter #(.CNT_W(W)) u_chained_time_counter (
    .clk(clk), .rst(rst), .div_sel(div_sel), .chan_start(chan_start),
    .chan_stop(chan_stop), .sync_all(sync_all), .lo_count(lo_count),
    .hi_count(hi_count), .lo_wave(lo_wave)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Sync with optional start/stop in the same cycle; on return k = 0.
  task automatic do_sync(input logic [1:0] st, input logic [1:0] sp);
    sync_all = 1'b1; chan_start = st; chan_stop = sp;
    cyc(1);
    sync_all = 1'b0; chan_start = 2'b00; chan_stop = 2'b00;
  endtask

  task automatic sweep(input int sel, input int kmax);
    int d;
    d = 1 << (2 * sel + 1);
    div_sel = 2'(sel);
    do_sync(2'b11, 2'b00);
    chk("R8 sync clear lo", int'(lo_count), 0);
    chk("R8 sync clear hi", int'(hi_count), 0);
    for (int k = 1; k <= kmax; k++) begin
      int t, hexp;
      cyc(1);
      t    = k / d;
      hexp = (k >= LAT) ? ((k - LAT) / (d * MOD)) % MOD : 0;
      chk("R2 R3 lo count", int'(lo_count), t % MOD);
      chk("R5 R6 hi count", int'(hi_count), hexp);
      chk("R4 wave", int'(lo_wave), ((t >= MOD) && ((t % MOD) < HALF)) ? 1 : 0);
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int snap;
    cyc(3);
    rst = 1'b0;
    // R1: reset state, no start given
    cyc(40);
    chk("R1 lo after reset", int'(lo_count), 0);
    chk("R1 hi after reset", int'(hi_count), 0);
    chk("R1 wave after reset", int'(lo_wave), 0);

    // R2 R3 R4 R5 over every tap; tap 0 runs past an upper wrap (R6)
    sweep(0, 2 * MOD * (MOD + 1) + 10);
    sweep(1, 8 * MOD * 3 + 10);
    sweep(2, 32 * MOD * 2 + 10);
    sweep(3, 128 * MOD + 40);

    // R7: stop lower channel, stop-wins, restart
    div_sel = 2'd0;
    do_sync(2'b11, 2'b00);
    cyc(20);
    chk("R7 lo before stop", int'(lo_count), 10);
    chan_stop = 2'b01; cyc(1); chan_stop = 2'b00;
    snap = int'(lo_count);
    cyc(30);
    chk("R7 lo holds when stopped", int'(lo_count), snap);
    chan_start = 2'b01; chan_stop = 2'b01; cyc(1);
    chan_start = 2'b00; chan_stop = 2'b00;
    cyc(20);
    chk("R7 stop wins over start", int'(lo_count), snap);
    chan_start = 2'b01; cyc(1); chan_start = 2'b00;
    cyc(20);
    chk("R7 restart advances", (int'(lo_count) != snap) ? 1 : 0, 1);

    // R8: sync keeps enables and flushes an edge pending after a wrap
    do_sync(2'b00, 2'b00);
    cyc(2);
    chk("R8 enables kept", int'(lo_count), 1);
    do_sync(2'b00, 2'b00);
    cyc(2 * MOD);
    chk("R8 wrapped lo", int'(lo_count), 0);
    chk("R8 wave high at wrap", int'(lo_wave), 1);
    do_sync(2'b00, 2'b00);
    cyc(6);
    chk("R8 pending edge flushed", int'(hi_count), 0);

    // R9: edges lost while upper channel stopped
    do_sync(2'b01, 2'b10);
    cyc(4 * MOD + 4);
    chk("R9 hi held while stopped", int'(hi_count), 0);
    chan_start = 2'b10; cyc(1); chan_start = 2'b00;
    cyc(5);
    chk("R9 lost edges not counted", int'(hi_count), 0);
    // next wrap at k = 6*MOD, visible LAT later; now k = 4*MOD+10
    cyc(2 * MOD - 10 + LAT);
    chk("R9 counts after restart", int'(hi_count), 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule